// File: doc/BRIEF.md
# Banked Working Register File

This block holds the general working registers of an 8-bit processor core. It has two banks of byte registers: a primary set and a shadow set. Each bank has an accumulator, a flag byte and six general bytes, and the six general bytes join into three pairs. The bank that is visible to reads and writes can be switched in a single clock. The switch can cover the whole bank, only the accumulator and flag group, or only the three general pairs. Two index registers sit outside the banks. Each of their bytes can be reached on its own.

A width input selects between a short mode, where pairs and index registers are 16 bits, and a long mode, where they are 24 bits. In short mode the top byte of a pair read has no meaning, so this block drives it as zero. A pair write in short mode leaves the stored top byte untouched. Reads are combinational. Writes and bank switches take effect at the rising clock edge. Every access finishes in one cycle and nothing can stall it, so the block has no valid/ready handshake, and every pin is a plain level. Instruction decoding and flag generation belong to other blocks.

Top module: `bwrf_top`

## Requirements
- R1: After reset every stored byte is zero, the primary bank is visible for both groups, and every read returns zero.
- R2: With wr_en=1 and wr_pair=0, wr_data[7:0] is written to the byte named by wr_bsel at the next edge, and rd_bsel reads it back. The codes are: 0 B, 1 C, 2 D, 3 E, 4 H, 5 L, 6 F, 7 A, 8 IX high, 9 IX low, 10 IY high, 11 IY low.
- R3: Pair codes are 0 BC, 1 DE, 2 HL, 3 AF, 4 IX, 5 IY. A pair read returns the high register in bits 15:8 and the low register in bits 7:0, where B, D, H and A are high and C, E, L and F are low. The AF pair always reads zero in bits 23:16, and an AF write ignores wr_data[23:16].
- R4: In long mode (long_mode=1), a pair write to BC, DE, HL, IX or IY stores all 24 bits of wr_data, and a pair read returns all 24 stored bits.
- R5: In short mode (long_mode=0), pair reads return zero in bits 23:16. A pair write stores only bits 15:0 and keeps the stored top byte, which reads back once long mode returns.
- R6: A pulse on xchg_all swaps the visible and hidden copies of A, F, B, C, D, E, H, L and the top bytes of BC, DE and HL, effective from the next edge.
- R7: A pulse on xchg_af swaps only A and F. The other registers keep their values.
- R8: A pulse on xchg_gp swaps only BC, DE and HL, including their top bytes. A, F, IX and IY are not banked and do not change.
- R9: When several exchange inputs are high in the same cycle, the AF group swaps if an odd number of xchg_all and xchg_af are high, and the pair group swaps if an odd number of xchg_all and xchg_gp are high.
- R10: A write in the same cycle as an exchange goes to the copy that was visible before that edge.
- R11: Byte codes 12 to 15 and pair codes 6 and 7 read as zero, and a write to any of them changes no stored byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| long_mode | input | 1 | 1 selects 24-bit pairs, 0 selects 16-bit pairs |
| wr_en | input | 1 | Write strobe for this cycle |
| wr_pair | input | 1 | 1 writes a pair (wr_psel), 0 writes a byte (wr_bsel) |
| wr_bsel | input | 4 | Byte register code for writes |
| wr_psel | input | 3 | Pair code for writes |
| wr_data | input | 24 | Write data; a byte write uses bits 7:0 |
| xchg_all | input | 1 | Swap both register groups |
| xchg_af | input | 1 | Swap the accumulator and flag group |
| xchg_gp | input | 1 | Swap the BC/DE/HL group |
| rd_bsel | input | 4 | Byte register code for the read port |
| rd_byte | output | 8 | Byte read data |
| rd_psel | input | 3 | Pair code for the read port |
| rd_pair | output | 24 | Pair read data |

## Verification
The bench targets partial exchanges and how they mix. A design that keeps a single bank bit would swap A and F together with the pairs, and a design that ORs the requests would swap on xchg_all plus xchg_af where the two should cancel. Writes issued in the same cycle as an exchange are checked against the bank visible before the edge, which catches a write steered by the next-state select. The bench also switches the width between writes, so a short-mode write that clears the top byte, or a short-mode read that leaks it, shows up as a miscompare. Reserved codes are written with all ones and then every register is read back, so a decoder that aliases them onto a real register is caught.

// File: rtl/bwrf_pkg.sv
`timescale 1ns/1ps
package bwrf_pkg;
  // byte register codes seen at the ports
  localparam logic [3:0] BC_B   = 4'd0;
  localparam logic [3:0] BC_C   = 4'd1;
  localparam logic [3:0] BC_D   = 4'd2;
  localparam logic [3:0] BC_E   = 4'd3;
  localparam logic [3:0] BC_H   = 4'd4;
  localparam logic [3:0] BC_L   = 4'd5;
  localparam logic [3:0] BC_F   = 4'd6;
  localparam logic [3:0] BC_A   = 4'd7;
  localparam logic [3:0] BC_IXH = 4'd8;
  localparam logic [3:0] BC_IXL = 4'd9;
  localparam logic [3:0] BC_IYH = 4'd10;
  localparam logic [3:0] BC_IYL = 4'd11;

  // pair codes seen at the ports
  localparam logic [2:0] PC_BC = 3'd0;
  localparam logic [2:0] PC_DE = 3'd1;
  localparam logic [2:0] PC_HL = 3'd2;
  localparam logic [2:0] PC_AF = 3'd3;
  localparam logic [2:0] PC_IX = 3'd4;
  localparam logic [2:0] PC_IY = 3'd5;

  // storage slots inside one bank; the first AF_SLOTS belong to the AF group
  localparam int SL_A  = 0;
  localparam int SL_F  = 1;
  localparam int SL_B  = 2;
  localparam int SL_C  = 3;
  localparam int SL_D  = 4;
  localparam int SL_E  = 5;
  localparam int SL_H  = 6;
  localparam int SL_L  = 7;
  localparam int SL_BU = 8;
  localparam int SL_DU = 9;
  localparam int SL_HU = 10;
  localparam int BANK_SLOTS = 11;
  localparam int AF_SLOTS   = 2;

  // storage slots of the unbanked index registers
  localparam int IX_L = 0;
  localparam int IX_H = 1;
  localparam int IX_U = 2;
  localparam int IY_L = 3;
  localparam int IY_H = 4;
  localparam int IY_U = 5;
  localparam int IDX_SLOTS = 6;
endpackage

// File: rtl/wrf_slots.sv
`timescale 1ns/1ps
module wrf_slots #(
  parameter int W = 8,
  parameter int N = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      wr_mask,
  input  logic [N-1:0][W-1:0] wr_data,
  output logic [N-1:0][W-1:0] q
);
  generate
    for (genvar i = 0; i < N; i++) begin : g_slot
      logic [W-1:0] r;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          r <= '0;
        else if (wr_mask[i]) r <= wr_data[i];
      end
      assign q[i] = r;

      assert_slot_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mask[i] |=> (q[i] == $past(wr_data[i])));
    end
  endgenerate

  // no strobe, no change anywhere in this array
  assert_hold_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(|wr_mask) |=> $stable(q));
endmodule

// File: rtl/wrf_xsel.sv
`timescale 1ns/1ps
module wrf_xsel (
  input  logic clk,
  input  logic rst_n,
  input  logic xchg_all,
  input  logic xchg_af,
  input  logic xchg_gp,
  output logic sel_af,
  output logic sel_gp
);
  logic flip_af, flip_gp;
  assign flip_af = xchg_all ^ xchg_af;
  assign flip_gp = xchg_all ^ xchg_gp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_af <= 1'b0;
      sel_gp <= 1'b0;
    end else begin
      sel_af <= sel_af ^ flip_af;
      sel_gp <= sel_gp ^ flip_gp;
    end
  end

  assert_swap_both_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (xchg_all && !xchg_af && !xchg_gp) |=>
      (sel_af != $past(sel_af)) && (sel_gp != $past(sel_gp)));

  assert_af_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (xchg_af && !xchg_all && !xchg_gp) |=>
      (sel_af != $past(sel_af)) && (sel_gp == $past(sel_gp)));

  assert_cancel_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (xchg_all && xchg_af) |=> (sel_af == $past(sel_af)));
endmodule

// File: rtl/wrf_wdec.sv
`timescale 1ns/1ps
module wrf_wdec
  import bwrf_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int WORD_W = 3 * BYTE_W
) (
  input  logic                                 wr_en,
  input  logic                                 wr_pair,
  input  logic [3:0]                           wr_bsel,
  input  logic [2:0]                           wr_psel,
  input  logic [WORD_W-1:0]                    wr_data,
  input  logic                                 long_mode,
  output logic [BANK_SLOTS-1:0]                bmask,
  output logic [BANK_SLOTS-1:0][BYTE_W-1:0]    bdata,
  output logic [IDX_SLOTS-1:0]                 imask,
  output logic [IDX_SLOTS-1:0][BYTE_W-1:0]     idata
);
  logic [BYTE_W-1:0] b0, b1, b2;
  assign b0 = wr_data[BYTE_W-1:0];
  assign b1 = wr_data[2*BYTE_W-1:BYTE_W];
  assign b2 = wr_data[WORD_W-1:2*BYTE_W];

  always_comb begin
    bmask = '0;
    imask = '0;
    for (int s = 0; s < BANK_SLOTS; s++) bdata[s] = b0;
    for (int s = 0; s < IDX_SLOTS; s++)  idata[s] = b0;
    if (wr_en && !wr_pair) begin
      case (wr_bsel)
        BC_B:   bmask[SL_B] = 1'b1;
        BC_C:   bmask[SL_C] = 1'b1;
        BC_D:   bmask[SL_D] = 1'b1;
        BC_E:   bmask[SL_E] = 1'b1;
        BC_H:   bmask[SL_H] = 1'b1;
        BC_L:   bmask[SL_L] = 1'b1;
        BC_F:   bmask[SL_F] = 1'b1;
        BC_A:   bmask[SL_A] = 1'b1;
        BC_IXH: imask[IX_H] = 1'b1;
        BC_IXL: imask[IX_L] = 1'b1;
        BC_IYH: imask[IY_H] = 1'b1;
        BC_IYL: imask[IY_L] = 1'b1;
        default: ;
      endcase
    end else if (wr_en && wr_pair) begin
      case (wr_psel)
        PC_BC: begin
          bmask[SL_B] = 1'b1; bdata[SL_B] = b1;
          bmask[SL_C] = 1'b1;
          bmask[SL_BU] = long_mode; bdata[SL_BU] = b2;
        end
        PC_DE: begin
          bmask[SL_D] = 1'b1; bdata[SL_D] = b1;
          bmask[SL_E] = 1'b1;
          bmask[SL_DU] = long_mode; bdata[SL_DU] = b2;
        end
        PC_HL: begin
          bmask[SL_H] = 1'b1; bdata[SL_H] = b1;
          bmask[SL_L] = 1'b1;
          bmask[SL_HU] = long_mode; bdata[SL_HU] = b2;
        end
        PC_AF: begin
          bmask[SL_A] = 1'b1; bdata[SL_A] = b1;
          bmask[SL_F] = 1'b1;
        end
        PC_IX: begin
          imask[IX_L] = 1'b1;
          imask[IX_H] = 1'b1; idata[IX_H] = b1;
          imask[IX_U] = long_mode; idata[IX_U] = b2;
        end
        PC_IY: begin
          imask[IY_L] = 1'b1;
          imask[IY_H] = 1'b1; idata[IY_H] = b1;
          imask[IY_U] = long_mode; idata[IY_U] = b2;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/bwrf_top.sv
`timescale 1ns/1ps
module bwrf_top
  import bwrf_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int WORD_W = 3 * BYTE_W,
  localparam int NBANK  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              long_mode,
  input  logic              wr_en,
  input  logic              wr_pair,
  input  logic [3:0]        wr_bsel,
  input  logic [2:0]        wr_psel,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              xchg_all,
  input  logic              xchg_af,
  input  logic              xchg_gp,
  input  logic [3:0]        rd_bsel,
  output logic [BYTE_W-1:0] rd_byte,
  input  logic [2:0]        rd_psel,
  output logic [WORD_W-1:0] rd_pair
);
  localparam logic [BANK_SLOTS-1:0] AF_MASK = BANK_SLOTS'((1 << AF_SLOTS) - 1);
  localparam logic [BANK_SLOTS-1:0] GP_MASK = ~AF_MASK;

  logic sel_af, sel_gp;
  logic [BANK_SLOTS-1:0]             bmask;
  logic [BANK_SLOTS-1:0][BYTE_W-1:0] bdata;
  logic [IDX_SLOTS-1:0]              imask;
  logic [IDX_SLOTS-1:0][BYTE_W-1:0]  idata;
  logic [NBANK-1:0][BANK_SLOTS-1:0][BYTE_W-1:0] bank_q;
  logic [IDX_SLOTS-1:0][BYTE_W-1:0]  idx_q;
  logic [BANK_SLOTS-1:0][BYTE_W-1:0] vis;

  wrf_xsel u_xsel (
    .clk(clk), .rst_n(rst_n),
    .xchg_all(xchg_all), .xchg_af(xchg_af), .xchg_gp(xchg_gp),
    .sel_af(sel_af), .sel_gp(sel_gp)
  );

  wrf_wdec #(.BYTE_W(BYTE_W)) u_wdec (
    .wr_en(wr_en), .wr_pair(wr_pair), .wr_bsel(wr_bsel), .wr_psel(wr_psel),
    .wr_data(wr_data), .long_mode(long_mode),
    .bmask(bmask), .bdata(bdata), .imask(imask), .idata(idata)
  );

  // each group writes into the copy its select bit names before the edge
  generate
    for (genvar k = 0; k < NBANK; k++) begin : g_bank
      logic [BANK_SLOTS-1:0] kmask;
      assign kmask = bmask & (((sel_af == 1'(k)) ? AF_MASK : '0) |
                              ((sel_gp == 1'(k)) ? GP_MASK : '0));
      wrf_slots #(.W(BYTE_W), .N(BANK_SLOTS)) u_slots (
        .clk(clk), .rst_n(rst_n), .wr_mask(kmask), .wr_data(bdata), .q(bank_q[k])
      );
    end
    for (genvar s = 0; s < BANK_SLOTS; s++) begin : g_vis
      if (s < AF_SLOTS) begin : g_af
        assign vis[s] = bank_q[sel_af][s];
      end else begin : g_gp
        assign vis[s] = bank_q[sel_gp][s];
      end
    end
  endgenerate

  wrf_slots #(.W(BYTE_W), .N(IDX_SLOTS)) u_index (
    .clk(clk), .rst_n(rst_n), .wr_mask(imask), .wr_data(idata), .q(idx_q)
  );

  always_comb begin
    case (rd_bsel)
      BC_B:    rd_byte = vis[SL_B];
      BC_C:    rd_byte = vis[SL_C];
      BC_D:    rd_byte = vis[SL_D];
      BC_E:    rd_byte = vis[SL_E];
      BC_H:    rd_byte = vis[SL_H];
      BC_L:    rd_byte = vis[SL_L];
      BC_F:    rd_byte = vis[SL_F];
      BC_A:    rd_byte = vis[SL_A];
      BC_IXH:  rd_byte = idx_q[IX_H];
      BC_IXL:  rd_byte = idx_q[IX_L];
      BC_IYH:  rd_byte = idx_q[IY_H];
      BC_IYL:  rd_byte = idx_q[IY_L];
      default: rd_byte = '0;
    endcase
  end

  logic [BYTE_W-1:0] p_up, p_hi, p_lo;
  always_comb begin
    p_up = '0;
    p_hi = '0;
    p_lo = '0;
    case (rd_psel)
      PC_BC: begin p_up = vis[SL_BU]; p_hi = vis[SL_B]; p_lo = vis[SL_C]; end
      PC_DE: begin p_up = vis[SL_DU]; p_hi = vis[SL_D]; p_lo = vis[SL_E]; end
      PC_HL: begin p_up = vis[SL_HU]; p_hi = vis[SL_H]; p_lo = vis[SL_L]; end
      PC_AF: begin p_hi = vis[SL_A]; p_lo = vis[SL_F]; end
      PC_IX: begin p_up = idx_q[IX_U]; p_hi = idx_q[IX_H]; p_lo = idx_q[IX_L]; end
      PC_IY: begin p_up = idx_q[IY_U]; p_hi = idx_q[IY_H]; p_lo = idx_q[IY_L]; end
      default: ;
    endcase
  end
  assign rd_pair = {(long_mode ? p_up : {BYTE_W{1'b0}}), p_hi, p_lo};

  assert_single_byte_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_pair) |-> $onehot0({bmask, imask}));

  assert_reserved_byte_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_pair && (wr_bsel > BC_IYL)) |-> ((bmask == '0) && (imask == '0)));

  assert_short_keeps_top_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_pair && !long_mode) |-> !bmask[SL_BU] && !bmask[SL_DU] &&
                                         !bmask[SL_HU] && !imask[IX_U] && !imask[IY_U]);
endmodule

// File: tb/bwrf_top_bench.sv
`timescale 1ns/1ps
module bwrf_top_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        long_mode = 1'b1;
  logic        wr_en = 1'b0, wr_pair = 1'b0;
  logic [3:0]  wr_bsel = '0;
  logic [2:0]  wr_psel = '0;
  logic [23:0] wr_data = '0;
  logic        xchg_all = 1'b0, xchg_af = 1'b0, xchg_gp = 1'b0;
  logic [3:0]  rd_bsel = '0;
  logic [7:0]  rd_byte;
  logic [2:0]  rd_psel = '0;
  logic [23:0] rd_pair;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  // reference model: visible and hidden contents, moved on every exchange
  logic [7:0]  cur [8];
  logic [7:0]  alt [8];
  logic [7:0]  curu [3];
  logic [7:0]  altu [3];
  logic [23:0] ix, iy;

  always #2 clk = ~clk;

  bwrf_top u_bwrf_top (
    .clk(clk), .rst_n(rst_n), .long_mode(long_mode),
    .wr_en(wr_en), .wr_pair(wr_pair), .wr_bsel(wr_bsel), .wr_psel(wr_psel),
    .wr_data(wr_data), .xchg_all(xchg_all), .xchg_af(xchg_af), .xchg_gp(xchg_gp),
    .rd_bsel(rd_bsel), .rd_byte(rd_byte), .rd_psel(rd_psel), .rd_pair(rd_pair)
  );

  function automatic logic [7:0] m_byte(input int c);
    if (c < 8) return cur[c];
    case (c)
      8:  return ix[15:8];
      9:  return ix[7:0];
      10: return iy[15:8];
      11: return iy[7:0];
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [23:0] m_pair(input int p, input bit lm);
    case (p)
      0: return {lm ? curu[0] : 8'h00, cur[0], cur[1]};
      1: return {lm ? curu[1] : 8'h00, cur[2], cur[3]};
      2: return {lm ? curu[2] : 8'h00, cur[4], cur[5]};
      3: return {8'h00, cur[7], cur[6]};
      4: return {lm ? ix[23:16] : 8'h00, ix[15:0]};
      5: return {lm ? iy[23:16] : 8'h00, iy[15:0]};
      default: return 24'h0;
    endcase
  endfunction

  task automatic model_update(input bit we, input bit pr, input int bs, input int ps,
                              input logic [23:0] d, input bit lm,
                              input bit xa, input bit xf, input bit xg);
    logic [7:0] t;
    if (we && !pr) begin
      if (bs < 8) cur[bs] = d[7:0];
      else if (bs == 8)  ix[15:8] = d[7:0];
      else if (bs == 9)  ix[7:0]  = d[7:0];
      else if (bs == 10) iy[15:8] = d[7:0];
      else if (bs == 11) iy[7:0]  = d[7:0];
    end else if (we && pr) begin
      if (ps <= 2) begin
        cur[2*ps] = d[15:8];
        cur[2*ps+1] = d[7:0];
        if (lm) curu[ps] = d[23:16];
      end else if (ps == 3) begin
        cur[7] = d[15:8];
        cur[6] = d[7:0];
      end else if (ps == 4) begin
        ix[15:0] = d[15:0];
        if (lm) ix[23:16] = d[23:16];
      end else if (ps == 5) begin
        iy[15:0] = d[15:0];
        if (lm) iy[23:16] = d[23:16];
      end
    end
    if (xa ^ xf) begin
      for (int i = 6; i < 8; i++) begin t = cur[i]; cur[i] = alt[i]; alt[i] = t; end
    end
    if (xa ^ xg) begin
      for (int i = 0; i < 6; i++) begin t = cur[i]; cur[i] = alt[i]; alt[i] = t; end
      for (int i = 0; i < 3; i++) begin t = curu[i]; curu[i] = altu[i]; altu[i] = t; end
    end
  endtask

  task automatic scan(input string tag);
    for (int c = 0; c < 16; c++) begin
      rd_bsel = 4'(c);
      #0.05;
      vectors++;
      if (rd_byte !== m_byte(c)) begin
        fails++;
        $display("FAIL %s byte code %0d actual=%h expected=%h", tag, c, rd_byte, m_byte(c));
      end
    end
    for (int p = 0; p < 8; p++) begin
      rd_psel = 3'(p);
      #0.05;
      vectors++;
      if (rd_pair !== m_pair(p, long_mode)) begin
        fails++;
        $display("FAIL %s pair code %0d actual=%h expected=%h", tag, p, rd_pair,
                 m_pair(p, long_mode));
      end
    end
  endtask

  task automatic step(input string tag, input bit we, input bit pr, input int bs,
                      input int ps, input logic [23:0] d, input bit lm,
                      input bit xa, input bit xf, input bit xg);
    wr_en = we; wr_pair = pr; wr_bsel = 4'(bs); wr_psel = 3'(ps); wr_data = d;
    long_mode = lm; xchg_all = xa; xchg_af = xf; xchg_gp = xg;
    @(posedge clk);
    model_update(we, pr, bs, ps, d, lm, xa, xf, xg);
    @(negedge clk);
    wr_en = 1'b0; xchg_all = 1'b0; xchg_af = 1'b0; xchg_gp = 1'b0;
    scan(tag);
  endtask

  task automatic idle(input string tag, input bit lm);
    step(tag, 0, 0, 0, 0, 24'h0, lm, 0, 0, 0);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) begin cur[i] = 8'h00; alt[i] = 8'h00; end
    for (int i = 0; i < 3; i++) begin curu[i] = 8'h00; altu[i] = 8'h00; end
    ix = 24'h0; iy = 24'h0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    scan("R1 in reset");
    rst_n = 1'b1;
    idle("R1", 1);

    // R2: every byte code written and read back
    for (int c = 0; c < 12; c++) step("R2", 1, 0, c, 0, 24'(c * 37 + 5), 1, 0, 0, 0);

    // R11: reserved codes must not touch storage
    for (int c = 12; c < 16; c++) step("R11", 1, 0, c, 0, 24'hFFFFFF, 1, 0, 0, 0);
    step("R11", 1, 1, 0, 6, 24'hFFFFFF, 1, 0, 0, 0);
    step("R11", 1, 1, 0, 7, 24'hFFFFFF, 1, 0, 0, 0);

    // R4: full-width pairs in long mode
    step("R4", 1, 1, 0, 0, 24'h123456, 1, 0, 0, 0);
    step("R4", 1, 1, 0, 1, 24'h789ABC, 1, 0, 0, 0);
    step("R4", 1, 1, 0, 2, 24'hDEF012, 1, 0, 0, 0);
    step("R4", 1, 1, 0, 4, 24'hA1B2C3, 1, 0, 0, 0);
    step("R4", 1, 1, 0, 5, 24'hD4E5F6, 1, 0, 0, 0);
    // R3: AF pair packing, top byte dropped
    step("R3", 1, 1, 0, 3, 24'hABCDEF, 1, 0, 0, 0);

    // R5: short mode hides the top byte and a short write keeps it
    idle("R5", 0);
    step("R5", 1, 1, 0, 0, 24'h997788, 0, 0, 0, 0);
    step("R5", 1, 1, 0, 4, 24'h553344, 0, 0, 0, 0);
    idle("R5", 1);

    // R6: whole-bank swap, fill the shadow copy, swap back
    step("R6", 0, 0, 0, 0, 24'h0, 1, 1, 0, 0);
    step("R6", 1, 1, 0, 0, 24'h0A0B0C, 1, 0, 0, 0);
    step("R6", 1, 0, 7, 0, 24'h00005A, 1, 0, 0, 0);
    step("R6", 1, 0, 6, 0, 24'h0000A5, 1, 0, 0, 0);
    step("R6", 1, 1, 0, 2, 24'h313233, 1, 0, 0, 0);
    step("R6", 0, 0, 0, 0, 24'h0, 1, 1, 0, 0);

    // R7: accumulator group alone
    step("R7", 0, 0, 0, 0, 24'h0, 1, 0, 1, 0);
    step("R7", 0, 0, 0, 0, 24'h0, 1, 0, 1, 0);
    // R8: pair group alone, index registers unchanged
    step("R8", 0, 0, 0, 0, 24'h0, 1, 0, 0, 1);
    idle("R8", 0);
    step("R8", 0, 0, 0, 0, 24'h0, 1, 0, 0, 1);

    // R9: simultaneous requests
    step("R9", 0, 0, 0, 0, 24'h0, 1, 1, 1, 0);
    step("R9", 0, 0, 0, 0, 24'h0, 1, 1, 0, 1);
    step("R9", 0, 0, 0, 0, 24'h0, 1, 1, 1, 1);
    step("R9", 0, 0, 0, 0, 24'h0, 1, 0, 1, 1);

    // R10: writes landing in the copy visible before the swap
    step("R10", 1, 0, 7, 0, 24'h0000C7, 1, 1, 0, 0);
    step("R10", 1, 1, 0, 1, 24'h445566, 1, 0, 0, 1);
    step("R10", 1, 1, 0, 3, 24'h00E1E2, 1, 0, 1, 0);
    idle("R10", 1);

    // mixed traffic
    for (int n = 0; n < 400; n++) begin
      int r;
      r = $urandom;
      step("R10 mixed", r[0], r[1], int'(r[5:2]), int'(r[8:6]), 24'($urandom),
           r[9] | r[10], r[11] & r[12], r[13] & r[14], r[15] & r[16]);
    end

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule